// File: doc/BRIEF.md
# Register-Configured Pad Router

This block sits between a row of IO pad cells and the peripherals of a chip. Software picks, for each pad, which peripheral function owns it by writing a small selection register. One write moves three things together: the pad's outgoing data, its output-enable, and its incoming data. GPIO is one of the functions a pad can be handed to, on the same terms as any other.

Every pad has one selection register, and all of them have the same width. Code 0 gives the pad to its GPIO bit, which is bidirectional and supplies its own enable. Code 1 gives the pad to a drive-only function, which always enables the pad. Code 2 gives it to a sense-only function, which never enables it. Any higher code leaves the pad undriven. A peripheral input that no pad is routed to reads zero. The registers sit behind a plain register port. A write takes effect on the next clock edge. Reads, error flags and all routing are combinational.

Top module: `pad_router`

## Requirements
- R1: After reset every selection register reads 0 and every pad is routed to its GPIO bit.
- R2: A write with `wr_en` high whose index field (address bits [5:2]) is below NUM_CELLS stores `wr_data[SEL_W-1:0]` into that cell's register at the next rising edge. `wr_err` is low for it.
- R3: A write whose index field is NUM_CELLS or more raises `wr_err` in the same cycle and changes no register.
- R4: A read of a valid index returns the register value zero-extended to DATA_W, with `rd_err` low. A read of an invalid index returns 0 with `rd_err` high. Both results are combinational.
- R5: Address bits outside [5:2] play no part in the decode, for writes or for reads.
- R6: Selection 0: `pad_out` = `gpio_out`, `pad_oe` = `gpio_oe`, and `gpio_in` = `pad_in` for that cell.
- R7: Selection 1: `pad_out` = `fn_tx` and `pad_oe` = 1 for that cell.
- R8: Selection 2: `pad_oe` = 0, `pad_out` = 0, and `fn_rx` = `pad_in` for that cell.
- R9: Any selection of 3 or more: `pad_oe` = 0 and `pad_out` = 0.
- R10: A `gpio_in` or `fn_rx` bit whose cell has not selected it is 0.
- R11: Routing is combinational. A change on a pad or on a peripheral input shows at the outputs with no clock edge in between.
- R12: Changing one cell's selection leaves the routing of every other cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_err | output | 1 | Write address does not map to a register |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |
| rd_err | output | 1 | Read address does not map to a register |
| pad_in | input | NUM_CELLS | Value seen at each pad |
| pad_out | output | NUM_CELLS | Value driven to each pad |
| pad_oe | output | NUM_CELLS | Output-enable for each pad |
| gpio_out | input | NUM_CELLS | GPIO outgoing data, one bit per cell |
| gpio_oe | input | NUM_CELLS | GPIO direction, one bit per cell |
| gpio_in | output | NUM_CELLS | GPIO incoming data, one bit per cell |
| fn_tx | input | NUM_CELLS | Drive-only function data, one per cell |
| fn_rx | output | NUM_CELLS | Sense-only function data, one per cell |

## Verification
A register write is issued while the clock is low and takes effect at the next rising edge. The bench therefore waits until the following low phase before it reads back or checks any routing. `wr_err`, `rd_data` and `rd_err` depend only on the addresses, so they are sampled one time step after the address is applied, with no clock edge in between. Routing checks work the same way. Pad and peripheral inputs are changed, and the outputs are compared one step later in the same clock phase. This confirms that the path through the selection registers holds no register.

// File: rtl/pad_router_pkg.sv
package pad_router_pkg;

  typedef enum logic [1:0] {
    KIND_GPIO  = 2'd0,
    KIND_DRIVE = 2'd1,
    KIND_SENSE = 2'd2,
    KIND_NONE  = 2'd3
  } fn_kind_e;

  function automatic fn_kind_e sel_kind(input logic [31:0] sel);
    fn_kind_e k;
    case (sel)
      32'd0:   k = KIND_GPIO;
      32'd1:   k = KIND_DRIVE;
      32'd2:   k = KIND_SENSE;
      default: k = KIND_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/pad_router_rst_sync.sv
module pad_router_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pad_router_regs.sv
module pad_router_regs #(
  parameter int NUM_CELLS = 4,
  parameter int SEL_W     = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_LO    = 2,
  parameter int IDX_HI    = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic                            wr_err,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            rd_err,
  output logic [NUM_CELLS-1:0][SEL_W-1:0] sel_q
);

  localparam int IDX_W = IDX_HI - IDX_LO + 1;

  logic [IDX_W-1:0]     wr_idx;
  logic [IDX_W-1:0]     rd_idx;
  logic [NUM_CELLS-1:0] wr_hit;
  logic [NUM_CELLS-1:0] rd_hit;
  logic [SEL_W-1:0]     wr_val;
  logic                 unused_bits;

  assign wr_idx = wr_addr[IDX_HI:IDX_LO];
  assign rd_idx = rd_addr[IDX_HI:IDX_LO];
  assign wr_val = wr_data[SEL_W-1:0];
  assign unused_bits = ^{wr_addr, rd_addr, wr_data};

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(c);

    logic             load_en;
    logic [SEL_W-1:0] sel_d;

    assign wr_hit[c] = (wr_idx == MY_IDX);
    assign rd_hit[c] = (rd_idx == MY_IDX);

    always_comb begin
      load_en = wr_en & wr_hit[c];
      sel_d   = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[c] <= '0;
      end else if (load_en) begin
        sel_q[c] <= sel_d;
      end
    end
  end

  assign wr_err = ~(|wr_hit);
  assign rd_err = ~(|rd_hit);

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      if (rd_hit[c]) begin
        rd_data[SEL_W-1:0] = sel_q[c];
      end
    end
  end

endmodule

// File: rtl/pad_router_cell.sv
module pad_router_cell
  import pad_router_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             pad_in,
  input  logic             gpio_out,
  input  logic             gpio_oe,
  input  logic             drv_out,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             gpio_in,
  output logic             sense_in
);

  fn_kind_e kind;

  always_comb begin
    kind     = sel_kind(32'(sel));
    pad_out  = 1'b0;
    pad_oe   = 1'b0;
    gpio_in  = 1'b0;
    sense_in = 1'b0;
    unique case (kind)
      KIND_GPIO: begin
        pad_out = gpio_out;
        pad_oe  = gpio_oe;
        gpio_in = pad_in;
      end
      KIND_DRIVE: begin
        pad_out = drv_out;
        pad_oe  = 1'b1;
      end
      KIND_SENSE: begin
        sense_in = pad_in;
      end
      KIND_NONE: begin
        pad_out = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pad_router.sv
module pad_router #(
  parameter int NUM_CELLS = 4,
  parameter int SEL_W     = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_LO    = 2,
  parameter int IDX_HI    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 wr_err,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_err,
  input  logic [NUM_CELLS-1:0] pad_in,
  output logic [NUM_CELLS-1:0] pad_out,
  output logic [NUM_CELLS-1:0] pad_oe,
  input  logic [NUM_CELLS-1:0] gpio_out,
  input  logic [NUM_CELLS-1:0] gpio_oe,
  output logic [NUM_CELLS-1:0] gpio_in,
  input  logic [NUM_CELLS-1:0] fn_tx,
  output logic [NUM_CELLS-1:0] fn_rx
);

  logic                            rst_sync_n;
  logic [NUM_CELLS-1:0][SEL_W-1:0] sel_q;

  pad_router_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pad_router_regs #(
    .NUM_CELLS (NUM_CELLS),
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDX_LO    (IDX_LO),
    .IDX_HI    (IDX_HI)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_err  (wr_err),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_err  (rd_err),
    .sel_q   (sel_q)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_route
    pad_router_cell #(.SEL_W(SEL_W)) u_cell (
      .sel      (sel_q[c]),
      .pad_in   (pad_in[c]),
      .gpio_out (gpio_out[c]),
      .gpio_oe  (gpio_oe[c]),
      .drv_out  (fn_tx[c]),
      .pad_out  (pad_out[c]),
      .pad_oe   (pad_oe[c]),
      .gpio_in  (gpio_in[c]),
      .sense_in (fn_rx[c])
    );
  end

endmodule

// File: rtl/pad_router_chk.sv
module pad_router_chk #(
  parameter int NUM_CELLS = 4,
  parameter int SEL_W     = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                            clk,
  input logic                            rst_sync_n,
  input logic                            wr_en,
  input logic                            wr_err,
  input logic [ADDR_W-1:0]               wr_addr,
  input logic [DATA_W-1:0]               wr_data,
  input logic [ADDR_W-1:0]               rd_addr,
  input logic [DATA_W-1:0]               rd_data,
  input logic                            rd_err,
  input logic [NUM_CELLS-1:0]            pad_in,
  input logic [NUM_CELLS-1:0]            pad_out,
  input logic [NUM_CELLS-1:0]            pad_oe,
  input logic [NUM_CELLS-1:0]            gpio_oe,
  input logic [NUM_CELLS-1:0]            gpio_in,
  input logic [NUM_CELLS-1:0]            fn_tx,
  input logic [NUM_CELLS-1:0]            fn_rx,
  input logic [NUM_CELLS-1:0][SEL_W-1:0] sel_q
);

  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'((1 << SEL_W) - 1);

  AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_err) |=> $stable(sel_q)); // R3

  AST_GOOD_WRITE_READS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_err) |=> ((rd_addr != $past(wr_addr)) ||
                            (rd_data == ($past(wr_data) & SEL_MASK)))); // R2

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_err |-> (rd_data == '0)); // R4

  AST_GPIO_IN_FROM_PAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((gpio_in & ~pad_in) == '0)); // R6

  AST_RX_FROM_PAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((fn_rx & ~pad_in) == '0)); // R8

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((gpio_in & fn_rx) == '0)); // R10

  AST_DRIVE_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (((pad_oe & ~gpio_oe) & (pad_out ^ fn_tx)) == '0)); // R7

endmodule

bind pad_router pad_router_chk #(
  .NUM_CELLS (NUM_CELLS),
  .SEL_W     (SEL_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_err     (wr_err),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .rd_err     (rd_err),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .gpio_oe    (gpio_oe),
  .gpio_in    (gpio_in),
  .fn_tx      (fn_tx),
  .fn_rx      (fn_rx),
  .sel_q      (sel_q)
);

// File: tb/pad_router_bench.sv
module pad_router_bench;

  localparam int N      = 4;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_err;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_err;
  logic [N-1:0]      pad_in, pad_out, pad_oe;
  logic [N-1:0]      gpio_out, gpio_oe, gpio_in;
  logic [N-1:0]      fn_tx, fn_rx;

  int tests  = 0;
  int fails  = 0;
  int exp_sel [N];

  always #4 clk = ~clk;

  pad_router #(.NUM_CELLS(N), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W))
  u_pad_router (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
    .fn_tx(fn_tx), .fn_rx(fn_rx)
  );

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic exp_err, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    check(req, "wr_err", DATA_W'(wr_err), DATA_W'(exp_err));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp_d,
                          input logic exp_err, input string req);
    rd_addr = a;
    #1;
    check(req, "rd_data", rd_data, exp_d);
    check(req, "rd_err", DATA_W'(rd_err), DATA_W'(exp_err));
  endtask

  task automatic check_routing();
    for (int c = 0; c < N; c++) begin
      logic eo, eoe, egi, erx;
      string rq;
      eo = 1'b0; eoe = 1'b0; egi = 1'b0; erx = 1'b0;
      case (exp_sel[c])
        0: begin eo = gpio_out[c]; eoe = gpio_oe[c]; egi = pad_in[c]; rq = "R6"; end
        1: begin eo = fn_tx[c]; eoe = 1'b1; rq = "R7"; end
        2: begin erx = pad_in[c]; rq = "R8"; end
        default: rq = "R9";
      endcase
      check(rq, $sformatf("pad_out[%0d]", c), DATA_W'(pad_out[c]), DATA_W'(eo));
      check(rq, $sformatf("pad_oe[%0d]", c),  DATA_W'(pad_oe[c]),  DATA_W'(eoe));
      check("R10", $sformatf("gpio_in[%0d]", c), DATA_W'(gpio_in[c]), DATA_W'(egi));
      check("R10", $sformatf("fn_rx[%0d]", c),   DATA_W'(fn_rx[c]),   DATA_W'(erx));
    end
  endtask

  task automatic drive_pattern(input int p);
    case (p)
      0: begin pad_in = 4'hF; gpio_out = 4'h0; gpio_oe = 4'h0; fn_tx = 4'hF; end
      1: begin pad_in = 4'h0; gpio_out = 4'hF; gpio_oe = 4'hF; fn_tx = 4'h0; end
      2: begin pad_in = 4'h5; gpio_out = 4'hA; gpio_oe = 4'h3; fn_tx = 4'h6; end
      default: begin pad_in = 4'hA; gpio_out = 4'h5; gpio_oe = 4'hC; fn_tx = 4'h9; end
    endcase
  endtask

  task automatic t_reset();
    for (int c = 0; c < N; c++) begin
      bus_read(ADDR_W'(c << 2), '0, 1'b0, "R1");
    end
    drive_pattern(2);
    #1;
    check("R1", "pad_out", DATA_W'(pad_out), DATA_W'(gpio_out));
    check("R1", "pad_oe",  DATA_W'(pad_oe),  DATA_W'(gpio_oe));
    check("R1", "gpio_in", DATA_W'(gpio_in), DATA_W'(pad_in));
  endtask

  task automatic t_write_read();
    bus_write(8'h08, 32'hFFFF_FFF6, 1'b0, "R2");
    exp_sel[2] = 2;
    bus_read(8'h08, 32'h2, 1'b0, "R4");
    bus_write(8'h08, 32'h0000_0000, 1'b0, "R2");
    exp_sel[2] = 0;
    bus_read(8'h08, 32'h0, 1'b0, "R2");
  endtask

  task automatic t_bad_addr();
    bus_write(8'h04, 32'h3, 1'b0, "R2");
    exp_sel[1] = 3;
    bus_write(8'h10, 32'h1, 1'b1, "R3");
    bus_write(8'h3C, 32'h2, 1'b1, "R3");
    for (int c = 0; c < N; c++) begin
      bus_read(ADDR_W'(c << 2), DATA_W'(exp_sel[c]), 1'b0, "R3");
    end
    bus_read(8'h14, '0, 1'b1, "R4");
    bus_read(8'h3C, '0, 1'b1, "R4");
  endtask

  task automatic t_alias();
    bus_write(8'hC7, 32'h1, 1'b0, "R5");
    exp_sel[1] = 1;
    bus_read(8'h04, 32'h1, 1'b0, "R5");
    bus_read(8'h87, 32'h1, 1'b0, "R5");
    bus_write(8'hD3, 32'h2, 1'b1, "R5");
    bus_read(8'h04, 32'h1, 1'b0, "R5");
  endtask

  task automatic t_sweep();
    for (int c = 0; c < N; c++) begin
      for (int s = 0; s < 4; s++) begin
        bus_write(ADDR_W'(c << 2), DATA_W'(s), 1'b0, "R2");
        exp_sel[c] = s;
        for (int p = 0; p < 4; p++) begin
          drive_pattern(p);
          #1;
          check_routing();
        end
      end
    end
  endtask

  task automatic t_comb();
    bus_write(8'h00, 32'h0, 1'b0, "R11");
    bus_write(8'h04, 32'h1, 1'b0, "R11");
    bus_write(8'h08, 32'h2, 1'b0, "R11");
    exp_sel[0] = 0; exp_sel[1] = 1; exp_sel[2] = 2;
    @(negedge clk);
    drive_pattern(0);
    #1;
    check("R11", "pad_out a", DATA_W'(pad_out[1:0]), DATA_W'(2'b10));
    drive_pattern(1);
    #1;
    check("R11", "pad_out b", DATA_W'(pad_out[1:0]), DATA_W'(2'b01));
    check("R11", "fn_rx b",   DATA_W'(fn_rx[2]), 32'd0);
    pad_in = 4'h4;
    #1;
    check("R11", "fn_rx c",   DATA_W'(fn_rx[2]), 32'd1);
  endtask

  task automatic t_indep();
    logic [N-1:0] po, poe;
    drive_pattern(3);
    #1;
    po = pad_out; poe = pad_oe;
    bus_write(8'h0C, 32'h1, 1'b0, "R12");
    exp_sel[3] = 1;
    #1;
    check("R12", "other pad_out", DATA_W'(pad_out[2:0]), DATA_W'(po[2:0]));
    check("R12", "other pad_oe",  DATA_W'(pad_oe[2:0]),  DATA_W'(poe[2:0]));
    check("R12", "changed oe",    DATA_W'(pad_oe[3]),    32'd1);
    check_routing();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    pad_in = '0; gpio_out = '0; gpio_oe = '0; fn_tx = '0;
    for (int c = 0; c < N; c++) exp_sel[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_bad_addr();
    t_alias();
    t_sweep();
    t_comb();
    t_indep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule